// File: doc/BRIEF.md
# Four-Pin GPIO Port with Bus-Clock Output

This block is a memory-mapped, four-pin bidirectional I/O port on a simple synchronous register bus. The bus has an address, a write strobe, write data and combinational read data. The port keeps an output-data latch and a direction register. From these it drives a per-pin output-enable vector and an output-value vector toward the pad cells. Pin levels come back through a two-flop synchroniser, and software reads them in the same register as the latch.

The direction register also holds a clock-output enable. When that enable is set, pin 0 leaves port control. It drives the internal bus clock with its output enabled, whatever its own direction bit and latch bit say. Software can load the output latch while a pin is still an input. When the pin is later turned to an output, it drives that prepared value straight away, so no stale level appears on the pin.

Top module: `gpio_clkout_port`

## Requirements
- R1: After a synchronous active-low reset, all direction bits and the clock-output enable are 0. pin_oe is 4'b0000 and a read of the direction register (address 0x05) returns 0x00.
- R2: A direction bit of 1 sets the matching pin_oe bit. A 0 clears it, so the pin is an input. This holds for pin 0 only while the clock output is off.
- R3: While the clock-output enable (bit 7 of the direction register at 0x05) is 1, pin_oe[0] is 1 and pin_out[0] follows clk, independent of direction bit 0 and latch bit 0.
- R4: Bits 6:4 of the direction register read as 0, and writing them changes nothing.
- R5: A write to the data register (address 0x01) updates the 4-bit output latch whatever the direction bits are. pin_out[3:1] always shows the latch, and pin_out[0] shows it while the clock output is off. A pin switched from input to output therefore drives the latched value on the same edge that sets its direction bit.
- R6: A read of the data register returns, per bit, the latch value for output pins and the synchronised pin level for input pins.
- R7: A change on pin_in becomes visible in the data-register read after exactly two rising clock edges.
- R8: While the clock output is on, read bit 0 of the data register returns latch bit 0.
- R9: Data-register read bits 7:4 are 0, and any address other than 0x01 and 0x05 reads 0x00.
- R10: Registers change only on a rising edge where bus_we is 1. With bus_we at 0, the state visible on the ports stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; also the source of the pin-0 clock output |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pin_in | input | 4 | Asynchronous pin levels from the pads |
| pin_out | output | 4 | Output values toward the pads |
| pin_oe | output | 4 | Per-pin output enables |

## Verification
The checker watches the bus every cycle. It confirms that direction writes reach pin_oe on the next edge, that a clock-enable write forces pin_oe[0] high, and that data writes reach pin_out[3:1]. It also confirms that reserved read bits stay 0 and that the visible state holds when no write strobe is present. Some behaviours need staged scenarios: the exact two-edge synchroniser latency, the per-bit mix of latch and pin level in reads, and the latch-first, direction-second sequence that gives a clean switch to output. The value of pin_out[0] half a cycle apart, which shows the clock passing through, is likewise only shown by bench scenarios.

// File: rtl/gpio_port_pkg.sv
// Package: shared widths, register addresses and bit positions of the GPIO port.
// Assumes an 8-bit register bus and a port no wider than the data bus minus one bit.
package gpio_port_pkg;
    localparam int PIN_W       = 4;
    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 8;
    localparam int SYNC_STAGES = 2;
    localparam int CKEN_BIT    = 7;
    localparam logic [ADDR_W-1:0] DATA_ADDR = 8'h01;
    localparam logic [ADDR_W-1:0] DIR_ADDR  = 8'h05;

    // Register state that the read mux and the pin mux both use.
    typedef struct packed {
        logic [PIN_W-1:0] latch;
        logic [PIN_W-1:0] dir;
        logic             cken;
    } port_state_t;
endpackage

// File: rtl/gpio_sync.sv
// Module: multi-stage synchroniser for asynchronous pin levels, one chain per bit.
// Assumes each pin is independent; no bus coherence between pins is promised.
module gpio_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the pin level through the flop chain; reset clears it.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], async_in[b]};
        end
        assign sync_out[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/gpio_regs.sv
// Module: output-data latch, direction bits and clock-output enable.
// Assumes writes are single-cycle strobes decoded against full addresses.
module gpio_regs
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output port_state_t       state
);
    logic wr_data;
    logic wr_dir;

    // Decode the write strobe per register.
    always_comb begin
        wr_data = bus_we && (bus_addr == DATA_ADDR);
        wr_dir  = bus_we && (bus_addr == DIR_ADDR);
    end

    // Latch updates regardless of direction so it can be preloaded.
    always_ff @(posedge clk) begin
        if (!rst_n)       state.latch <= '0;
        else if (wr_data) state.latch <= bus_wdata[PIN_W-1:0];
    end

    // Direction bits and clock enable; reserved bits are not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state.dir  <= '0;
            state.cken <= 1'b0;
        end else if (wr_dir) begin
            state.dir  <= bus_wdata[PIN_W-1:0];
            state.cken <= bus_wdata[CKEN_BIT];
        end
    end
endmodule

// File: rtl/gpio_readmux.sv
// Module: combinational read-data selection for the port registers.
// Assumes unmapped addresses return zero and reads have no side effects.
module gpio_readmux
    import gpio_port_pkg::*;
(
    input  logic [ADDR_W-1:0] bus_addr,
    input  port_state_t       state,
    input  logic [PIN_W-1:0]  pin_sync,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [PIN_W-1:0] data_view;

    // Per bit: latch for outputs, synchronised level for inputs; bit 0 latch under clock output.
    always_comb begin
        data_view = (state.dir & state.latch) | (~state.dir & pin_sync);
        if (state.cken) data_view[0] = state.latch[0];
    end

    // Select the register image addressed on the bus.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == DATA_ADDR) begin
            bus_rdata[PIN_W-1:0] = data_view;
        end else if (bus_addr == DIR_ADDR) begin
            bus_rdata[PIN_W-1:0] = state.dir;
            bus_rdata[CKEN_BIT]  = state.cken;
        end
    end
endmodule

// File: rtl/gpio_pinmux.sv
// Module: drives pad value and enable per pin, with the clock override on pin 0.
// Assumes the pad cell gates pin_out with pin_oe; value is always the latch so it is ready early.
module gpio_pinmux
    import gpio_port_pkg::*;
(
    input  logic             clk,
    input  port_state_t      state,
    output logic [PIN_W-1:0] pin_out,
    output logic [PIN_W-1:0] pin_oe
);
    for (genvar p = 0; p < PIN_W; p++) begin : g_pin
        if (p == 0) begin : g_clk_pin
            // Pin 0: bus clock replaces port control when enabled.
            always_comb begin
                pin_out[p] = state.cken ? clk  : state.latch[p];
                pin_oe[p]  = state.cken ? 1'b1 : state.dir[p];
            end
        end else begin : g_plain_pin
            // Other pins: latch value, direction bit as enable.
            always_comb begin
                pin_out[p] = state.latch[p];
                pin_oe[p]  = state.dir[p];
            end
        end
    end
endmodule

// File: rtl/gpio_clkout_port.sv
// Module: top of the four-pin GPIO port with bus-clock output on pin 0.
// Assumes pin_in is asynchronous and the bus is synchronous to clk.
module gpio_clkout_port
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe
);
    port_state_t      state;
    logic [PIN_W-1:0] pin_sync;

    gpio_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .state     (state)
    );

    gpio_readmux i_rmux (
        .bus_addr  (bus_addr),
        .state     (state),
        .pin_sync  (pin_sync),
        .bus_rdata (bus_rdata)
    );

    gpio_pinmux i_pmux (
        .clk     (clk),
        .state   (state),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );
endmodule

// File: rtl/gpio_port_checker.sv
// Module: cycle-level properties of the GPIO port, observed at its ports only.
// Assumes it is attached by the bind below.
module gpio_port_checker
    import gpio_port_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [PIN_W-1:0]  pin_out,
    input logic [PIN_W-1:0]  pin_oe
);
    assert_reset_oe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pin_oe == '0);

    assert_dir_to_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == DIR_ADDR) |=> pin_oe[PIN_W-1:1] == $past(bus_wdata[PIN_W-1:1]));

    assert_clk_forces_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == DIR_ADDR && bus_wdata[CKEN_BIT]) |=> pin_oe[0]);

    assert_reserved_dir_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == DIR_ADDR) |-> bus_rdata[CKEN_BIT-1:PIN_W] == '0);

    assert_latch_to_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == DATA_ADDR) |=> pin_out[PIN_W-1:1] == $past(bus_wdata[PIN_W-1:1]));

    assert_data_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == DATA_ADDR) |-> bus_rdata[DATA_W-1:PIN_W] == '0);

    assert_hold_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && $past(rst_n)) |=> $stable(pin_oe) && $stable(pin_out[PIN_W-1:1]));
endmodule

bind gpio_clkout_port gpio_port_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/test_gpio_clkout_port.sv
// Bench: vector table for the main register behaviour, then directed corner cases.
module test_gpio_clkout_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [3:0] pin_in = 4'b1010;
    logic [3:0] pin_out;
    logic [3:0] pin_oe;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_clkout_port i_gpio_clkout_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Vector: we, addr, wdata, expected rdata, oe, out, out mask. Pins stay 4'b1010.
    localparam int NV = 12;
    localparam logic [36:0] VEC [NV] = '{
        {1'b0, 8'h01, 8'h00, 8'h0A, 4'h0, 4'h0, 4'hF},  // R6 all inputs
        {1'b1, 8'h01, 8'h05, 8'h0A, 4'h0, 4'h5, 4'hF},  // R5 preload as input
        {1'b1, 8'h05, 8'h03, 8'h03, 4'h3, 4'h5, 4'hF},  // R2
        {1'b0, 8'h01, 8'h00, 8'h09, 4'h3, 4'h5, 4'hF},  // R6 mixed
        {1'b1, 8'h05, 8'hFF, 8'h8F, 4'hF, 4'h5, 4'hE},  // R4 R3
        {1'b0, 8'h01, 8'h00, 8'h05, 4'hF, 4'h5, 4'hE},  // R8
        {1'b1, 8'h01, 8'hF4, 8'h04, 4'hF, 4'h4, 4'hE},  // R9 R8
        {1'b1, 8'h05, 8'h70, 8'h00, 4'h0, 4'h4, 4'hF},  // R4
        {1'b0, 8'h02, 8'h00, 8'h00, 4'h0, 4'h4, 4'hF},  // R9 unmapped
        {1'b0, 8'h05, 8'hFF, 8'h00, 4'h0, 4'h4, 4'hF},  // R10 no strobe
        {1'b0, 8'h01, 8'h00, 8'h0A, 4'h0, 4'h4, 4'hF},  // R6
        {1'b1, 8'h05, 8'h0C, 8'h0C, 4'hC, 4'h4, 4'hF}   // R2
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 3, 10: return "R6";
            1:        return "R5";
            2, 11:    return "R2";
            4:        return "R3/R4";
            5, 6:     return "R8/R9";
            7:        return "R4";
            8:        return "R9";
            default:  return "R10";
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at falling edge, sample 2 ns after the rising edge.
    task automatic bus_cycle(logic we, logic [7:0] addr, logic [7:0] wd);
        @(negedge clk);
        bus_we = we; bus_addr = addr; bus_wdata = wd;
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        check("R1 oe", {4'h0, pin_oe}, 8'h00);
        bus_addr = 8'h05;
        #1 check("R1 dir read", bus_rdata, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        bus_cycle(1'b0, 8'h01, 8'h00);
        bus_cycle(1'b0, 8'h01, 8'h00);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            bus_cycle(VEC[i][36], VEC[i][35:28], VEC[i][27:20]);
            check({vec_tag(i), " rdata"}, bus_rdata, VEC[i][19:12]);
            check({vec_tag(i), " oe"}, {4'h0, pin_oe}, {4'h0, VEC[i][11:8]});
            check({vec_tag(i), " out"}, {4'h0, pin_out & VEC[i][3:0]},
                  {4'h0, VEC[i][7:4] & VEC[i][3:0]});
        end

        // R7: two-edge synchroniser latency, all pins inputs
        bus_cycle(1'b1, 8'h05, 8'h00);
        @(negedge clk); pin_in = 4'b0101; bus_we = 1'b0; bus_addr = 8'h01;
        @(posedge clk); #2;
        check("R7 after one edge", bus_rdata, 8'h0A);
        @(posedge clk); #2;
        check("R7 after two edges", bus_rdata, 8'h05);

        // R5: preload latch as input, then switch to output
        bus_cycle(1'b1, 8'h01, 8'h06);
        check("R5 oe still off", {4'h0, pin_oe}, 8'h00);
        bus_cycle(1'b1, 8'h05, 8'h0F);
        check("R5 oe on", {4'h0, pin_oe}, 8'h0F);
        check("R5 out at switch", {4'h0, pin_out}, 8'h06);

        // R3: clock output with direction bit 0 clear and latch bit 0 clear
        bus_cycle(1'b1, 8'h05, 8'h80);
        check("R3 oe0 forced", {7'h0, pin_oe[0]}, 8'h01);
        check("R3 clk high", {7'h0, pin_out[0]}, 8'h01);
        @(negedge clk); #2;
        check("R3 clk low", {7'h0, pin_out[0]}, 8'h00);

        // R1 again: mid-run reset clears everything
        @(negedge clk); rst_n = 1'b0; bus_we = 1'b0;
        @(posedge clk); #2;
        check("R1 oe after reset", {4'h0, pin_oe}, 8'h00);
        bus_addr = 8'h05;
        #1 check("R1 dir after reset", bus_rdata, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #2;
        finish_run();
    end
endmodule